// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses that one SDRAM read or write burst walks through. A start request carries a starting column, a three-bit length code and an ordering select. The block then emits one column per clock. Each beat carries a valid flag, and the final beat of a fixed-length burst is also marked. A done pulse follows the end of every burst.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size. The wrap is either sequential or interleaved. In full-page mode the block steps through all columns and wraps at the top of the page. It keeps going until a stop request arrives. A stop can cut off a burst of any length. A new start is taken on any clock, even in the middle of a burst. This lets a memory controller issue column commands back to back with no idle cycle between them.

Top module: `colBurstGen`

## Requirements
- R1: While reset (`rstN` low) is applied and after it is released with no start, `colValid`, `colLast` and `burstDone` are low.
- R2: A start sampled at a clock edge makes `colValid` high in the following cycle, with `colOut` equal to the start column.
- R3: With `interleave` low and a fixed length BL, beat j shows the start column with its low log2(BL) bits replaced by (start low bits + j) mod BL. The upper bits do not change.
- R4: With `interleave` high and a fixed length BL, beat j shows the start column with its low log2(BL) bits replaced by (start low bits XOR j).
- R5: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Codes 4, 5 and 6 give a single beat.
- R6: Length code 7 (full page) increments the whole column by one each beat, wrapping from 1023 to 0. The `interleave` input has no effect in this mode, and `colLast` never rises in it.
- R7: `colLast` is high exactly on the final beat of a fixed-length burst.
- R8: `burstDone` is high for one cycle, in the cycle right after the final beat.
- R9: A stop request sampled during a beat makes that beat the last one shown. `colValid` drops in the next cycle and `burstDone` pulses. A stop request while idle has no effect.
- R10: A start during a burst replaces it, and the new start column appears in the next cycle with no idle cycle. A start wins over a stop in the same cycle, and the cut burst still gets its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startValid | input | 1 | Load a new burst this cycle |
| startCol | input | 10 | Starting column address |
| lenCode | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page, others:1) |
| interleave | input | 1 | 1 selects interleaved order, 0 selects sequential |
| stopReq | input | 1 | End the current burst after the beat now shown |
| colOut | output | 10 | Current column address |
| colValid | output | 1 | colOut holds a beat of a burst |
| colLast | output | 1 | Current beat is the final beat of a fixed-length burst |
| burstDone | output | 1 | One-cycle pulse after a burst ends |

## Verification
Bursts of length 8 and 4 are run from unaligned starting columns in both orders. Sequential and interleaved sequences only differ when the start is not aligned, so this separates them. It also shows that the upper bits stay fixed across the wrap. Single-beat codes, including the unused codes, check that no stray beat follows. A full-page run that crosses column 1023 checks the page wrap. Stops in the middle, at the last beat, while idle and together with a new start, plus starts that replace a running burst, check the ends of bursts and the handover between them.

// File: rtl/colBurstPkg.sv
package colBurstPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new start
    logic step;   // advance to the next beat
  } burstStrobe_t;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] LEN_FULL_PAGE = 3'd7;
  localparam int MAX_FIXED_CODE = 3;  // code 3 -> 8 beats
endpackage

// File: rtl/colBurstPath.sv
module colBurstPath
  import colBurstPkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  burstStrobe_t         strobe,
  input  logic [COL_W-1:0]     startCol,
  input  logic [CODE_W-1:0]    lenCode,
  input  logic                 interleave,
  output logic [COL_W-1:0]     colOut,
  output logic                 lastBeat
);
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] maskQ;
  logic             fullQ;
  logic             ilQ;

  logic [COL_W-1:0] maskNext;
  logic [COL_W-1:0] maskEff;
  logic [COL_W-1:0] lowSel;

  // wrap mask for fixed lengths: BL-1; unknown codes behave as length 1
  always_comb begin
    maskNext = '0;
    if (int'(lenCode) <= MAX_FIXED_CODE)
      maskNext = COL_W'((1 << lenCode) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
      maskQ <= '0;
      fullQ <= 1'b0;
      ilQ   <= 1'b0;
    end else if (strobe.load) begin
      baseQ <= startCol;
      beatQ <= '0;
      maskQ <= maskNext;
      fullQ <= (lenCode == LEN_FULL_PAGE);
      ilQ   <= interleave;
    end else if (strobe.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  always_comb begin
    maskEff = fullQ ? '1 : maskQ;
    lowSel  = (ilQ && !fullQ) ? (baseQ ^ beatQ) : (baseQ + beatQ);
    colOut  = (baseQ & ~maskEff) | (lowSel & maskEff);
  end

  // beat index BL-1 equals the wrap mask
  assign lastBeat = !fullQ && (beatQ == maskQ);
endmodule

// File: rtl/colBurstCtrl.sv
module colBurstCtrl
  import colBurstPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic         stopReq,
  input  logic         lastBeat,
  output burstStrobe_t strobe,
  output logic         colValid,
  output logic         colLast,
  output logic         burstDone
);
  logic activeQ;
  logic doneQ;
  logic endNow;

  assign endNow = activeQ && (lastBeat || stopReq);

  always_comb begin
    strobe.load = startValid;
    strobe.step = activeQ && !startValid && !endNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= endNow;
      if (startValid)
        activeQ <= 1'b1;
      else if (endNow)
        activeQ <= 1'b0;
    end
  end

  assign colValid  = activeQ;
  assign colLast   = activeQ && lastBeat;
  assign burstDone = doneQ;
endmodule

// File: rtl/colBurstGen.sv
module colBurstGen
  import colBurstPkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [COL_W-1:0]  startCol,
  input  logic [CODE_W-1:0] lenCode,
  input  logic              interleave,
  input  logic              stopReq,
  output logic [COL_W-1:0]  colOut,
  output logic              colValid,
  output logic              colLast,
  output logic              burstDone
);
  burstStrobe_t strobe;
  logic         lastBeat;

  colBurstCtrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .stopReq   (stopReq),
    .lastBeat  (lastBeat),
    .strobe    (strobe),
    .colValid  (colValid),
    .colLast   (colLast),
    .burstDone (burstDone)
  );

  colBurstPath #(.COL_W(COL_W)) pathI (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startCol  (startCol),
    .lenCode   (lenCode),
    .interleave(interleave),
    .colOut    (colOut),
    .lastBeat  (lastBeat)
  );
endmodule

// File: rtl/colBurstChk.sv
module colBurstChk
  import colBurstPkg::*;
#(
  parameter int COL_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [COL_W-1:0]  startCol,
  input logic [CODE_W-1:0] lenCode,
  input logic              stopReq,
  input logic [COL_W-1:0]  colOut,
  input logic              colValid,
  input logic              colLast,
  input logic              burstDone
);
  assert_first_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (colValid && colOut == $past(startCol)));

  assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);

  assert_done_follows_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> $past(colValid && (colLast || stopReq)));

  assert_end_goes_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && (colLast || stopReq) && !startValid) |=> (!colValid && burstDone));

  assert_idle_stays_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!colValid && !startValid) |=> !colValid);

  assert_full_page_no_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && lenCode == LEN_FULL_PAGE) |=> !colLast);

  assert_burst_continues_R3: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !colLast && !stopReq && !startValid) |=> colValid);
endmodule

bind colBurstGen colBurstChk #(.COL_W(COL_W)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .startCol  (startCol),
  .lenCode   (lenCode),
  .stopReq   (stopReq),
  .colOut    (colOut),
  .colValid  (colValid),
  .colLast   (colLast),
  .burstDone (burstDone)
);

// File: tb/colBurstGen_tb_top.sv
module colBurstGen_tb_top;
  typedef struct packed {
    logic [9:0] col;
    logic       last;
  } beat_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [9:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic       stopReq = 1'b0;
  logic [9:0] colOut;
  logic       colValid;
  logic       colLast;
  logic       burstDone;

  int checks = 0;
  int errors = 0;
  beat_t expQ[$];
  logic prevEnd = 1'b0;

  always #4 clk = ~clk;

  colBurstGen dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .stopReq(stopReq),
    .colOut(colOut), .colValid(colValid), .colLast(colLast), .burstDone(burstDone)
  );

  function automatic int beatsOf(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 1024;
      default: return 1;
    endcase
  endfunction

  // expected column from R3, R4, R6
  function automatic logic [9:0] expCol(input logic [9:0] base, input logic [2:0] code,
                                        input logic il, input int j);
    int n;
    logic [9:0] m;
    logic [9:0] jj;
    n  = beatsOf(code);
    jj = 10'(j);
    if (code == 3'd7) return base + jj;
    m = 10'(n - 1);
    if (il) return (base & ~m) | ((base ^ jj) & m);
    return (base & ~m) | ((base + jj) & m);
  endfunction

  // cutMode: 0 stop, 1 preempt by next start, 2 preempt with stop also high
  task automatic doBurst(input logic [9:0] col, input logic [2:0] code, input logic il,
                         input int cutAt, input int cutMode);
    int n;
    int cnt;
    n   = beatsOf(code);
    cnt = (cutAt >= 0) ? cutAt + 1 : n;
    for (int j = 0; j < cnt; j++) begin
      beat_t b;
      b.col  = expCol(col, code, il, j);
      b.last = (code != 3'd7) && (j == n - 1);
      expQ.push_back(b);
    end
    startValid = 1'b1;
    startCol   = col;
    lenCode    = code;
    interleave = il;
    @(posedge clk); #1;
    startValid = 1'b0;
    stopReq    = 1'b0;
    for (int j = 0; j < cnt; j++) begin
      if (j == cutAt) begin
        if (cutMode == 0) begin
          stopReq = 1'b1;
          @(posedge clk); #1;
          stopReq = 1'b0;
        end else if (cutMode == 2) begin
          stopReq = 1'b1;
        end
        return;
      end
      @(posedge clk); #1;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      logic endNow;
      endNow = 1'b0;
      checks++;
      if (burstDone !== prevEnd) begin
        errors++;
        $display("FAIL R8 R9 done pulse: got %0b expected %0b at %0t", burstDone, prevEnd, $time);
      end
      if (colValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R9 R10 unexpected beat: got col %0h expected no beat", colOut);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          if (colOut !== e.col || colLast !== e.last) begin
            errors++;
            $display("FAIL R2 R3 R4 R5 R6 R7 beat: got col %0h last %0b expected col %0h last %0b",
                     colOut, colLast, e.col, e.last);
          end
          endNow = e.last || stopReq;
        end
      end
      prevEnd = endNow;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    checks++;  // R1 during reset
    if (colValid !== 1'b0 || colLast !== 1'b0 || burstDone !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %0b%0b%0b expected 000", colValid, colLast, burstDone);
    end
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R3 sequential length 8, unaligned start
    doBurst(10'h0A5, 3'd3, 1'b0, -1, 0);
    // R4 interleaved length 8
    doBurst(10'h0A5, 3'd3, 1'b1, -1, 0);
    // R3 length 4 wrap inside top block
    doBurst(10'h3FE, 3'd2, 1'b0, -1, 0);
    // R4 length 4 interleaved
    doBurst(10'h101, 3'd2, 1'b1, -1, 0);
    // R5 length 2, length 1 and unused codes
    doBurst(10'h011, 3'd1, 1'b1, -1, 0);
    doBurst(10'h077, 3'd0, 1'b0, -1, 0);
    doBurst(10'h078, 3'd5, 1'b1, -1, 0);
    doBurst(10'h079, 3'd6, 1'b0, -1, 0);
    doBurst(10'h07A, 3'd4, 1'b0, -1, 0);
    // R6 full page crossing the page end, then with interleave set
    doBurst(10'd1020, 3'd7, 1'b0, 6, 0);
    doBurst(10'd3, 3'd7, 1'b1, 3, 0);
    // R9 stop in the middle of a length-8 burst
    doBurst(10'h2C3, 3'd3, 1'b0, 2, 0);
    // R9 stop on the last beat
    doBurst(10'h2C3, 3'd2, 1'b0, 3, 0);
    // R9 stop while idle
    @(posedge clk); #1;
    stopReq = 1'b1;
    @(posedge clk); #1;
    stopReq = 1'b0;
    @(posedge clk); #1;
    // R10 preempt mid-burst, then at last beat, then start with stop
    doBurst(10'h200, 3'd3, 1'b0, 3, 1);
    doBurst(10'h055, 3'd1, 1'b1, 1, 1);
    doBurst(10'h1F0, 3'd3, 1'b1, 4, 2);
    doBurst(10'h3F9, 3'd2, 1'b0, -1, 0);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 R10 missing beats: got %0d left expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule